// File: doc/BRIEF.md
# Budgeted Byte-Inversion Codec for a Narrow Subrank Bus

The block prepares a compressed cache line for transfer over an 8-bit subrank data bus and undoes the preparation on the receive side. Before it sends a byte, the transmitter may invert it. It does so when inversion lowers the number of bus wires that change state, compared with the byte sent just before it. Each byte that is eligible for inversion needs one flag bit, and the flag bits travel in up to three flag bytes. These flag bytes sit between the line's header byte and its payload. They use space that compression has freed inside the fixed 64-byte slot, so the number of flag bytes is bounded by that free space.

The transmit side takes the header byte, the compressed size in bytes (header included) and the payload bytes all at once. It then chooses an inversion budget and writes the chosen budget into a two-bit field of the header. Next it scans the payload once to decide the flags, and finally sends the frame one byte per clock. The receive side takes the same byte stream together with the compressed size. It reads the budget back from the header, collects the flag bytes and delivers the header and the restored payload. The flag bytes are not delivered.

Top module: `dbi_codec`

## Requirements
- R1: The sent header equals the supplied header, except that bits [4:3] hold the budget k. For a size s in bytes, k = min(3, 64 - s). When s <= 1 (no payload), k = 0.
- R2: A frame is sent on consecutive cycles with no gaps, in this order: the header, then k flag bytes, then the n = s - 1 payload bytes. The first and last markers are raised on the first and last bytes of the frame. The header appears n clock edges after the edge that accepts the start.
- R3: A covered payload byte is sent inverted when more than 4 of its bits differ from the previously sent byte. At exactly 4 differing bits it is sent true.
- R4: With k > 0, the covered payload bytes are those whose index is a multiple of the stride ceil(n / (8k)), counting from index 0. Uncovered bytes are always sent true, and with k = 0 no byte is inverted.
- R5: Flag j belongs to the j-th covered byte (1 means inverted). It sits in flag byte j/8 at bit j%8. Any flag bits left unused are zero.
- R6: Payload byte 0 is compared with the header as it was sent. Every later byte is compared with the previous payload byte as it was sent.
- R7: The receive side delivers the header and then the original payload bytes, each one clock edge after the byte arrives. Flag bytes produce no output. The last marker goes with the final payload byte, or with the header when n = 0.
- R8: While reset is asserted, the busy, transmit-valid and receive-output-valid signals are low.
- R9: A start raised while the transmitter is busy is ignored. The frame in progress is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Accept a new line while idle |
| tx_hdr | input | 8 | Header byte of the compressed line |
| tx_size | input | 7 | Compressed size in bytes, header included (1..64) |
| tx_payload | input | 504 | Payload bytes, byte i at bits [8i+7:8i] |
| tx_busy | output | 1 | Transmitter is scanning or sending |
| tx_valid | output | 1 | tx_byte carries a frame byte |
| tx_first | output | 1 | Current byte is the header |
| tx_last | output | 1 | Current byte ends the frame |
| tx_byte | output | 8 | Byte on the subrank bus |
| rx_valid | input | 1 | rx_byte carries a frame byte |
| rx_first | input | 1 | Current received byte is the header |
| rx_size | input | 7 | Compressed size, sampled with the header |
| rx_byte | input | 8 | Received bus byte |
| rx_out_valid | output | 1 | rx_out_byte carries a restored byte |
| rx_out_first | output | 1 | Restored byte is the header |
| rx_out_last | output | 1 | Restored byte ends the line |
| rx_out_byte | output | 8 | Header or restored payload byte |

## Verification
Two cases are the hardest to produce by chance: a covered byte that sits exactly on the four-bit threshold, and an uncovered byte that would have been inverted had it been covered. Random payloads almost never place these on the right indices. The stimulus therefore builds payloads backwards from the bytes that should appear on the bus: a two-byte line is placed on the threshold against the rewritten header, and an alternating all-zeros/all-ones line of 29 payload bytes forces a stride of two. A start is also raised again during a long scan with different inputs, and the frame that comes out must be the one already accepted.

// File: rtl/dbi_codec_pkg.sv
package dbi_codec_pkg;

  localparam int MODE_LSB = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_SEND} enc_state_e;

  function automatic logic [3:0] ones8(input logic [7:0] b);
    logic [3:0] c;
    c = '0;
    for (int i = 0; i < 8; i++) c = c + {3'b000, b[i]};
    return c;
  endfunction

  // budget: as many flag bytes as fit the free part of the slot
  function automatic logic [1:0] pick_mode(input int unsigned size,
                                           input int unsigned slot,
                                           input int unsigned maxf);
    int unsigned spare;
    if (size <= 1 || size > slot) return 2'd0;
    spare = slot - size;
    return (spare < maxf) ? 2'(spare) : 2'(maxf);
  endfunction

  // smallest stride s with s*8k >= n
  function automatic int unsigned pick_stride(input int unsigned n,
                                              input int unsigned k,
                                              input int unsigned slot);
    int unsigned st;
    st = 0;
    if (k == 0) return 1;
    for (int unsigned s = 1; s <= slot; s++)
      if (st == 0 && s * 8 * k >= n) st = s;
    return (st == 0) ? 1 : st;
  endfunction

endpackage

// File: rtl/dbi_walk.sv
module dbi_walk #(
  parameter int STW    = 7,
  parameter int FW     = 5,
  parameter int NFLAGS = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic [STW-1:0] stride,
  output logic           covered,
  output logic [FW-1:0]  fidx
);

  logic [STW-1:0] ph_q, ph_n;
  logic [FW-1:0]  fi_q, fi_n;

  always_comb begin
    ph_n = ph_q;
    fi_n = fi_q;
    if (clr) begin
      ph_n = '0;
      fi_n = '0;
    end else if (adv) begin
      if (ph_q == '0) fi_n = fi_q + FW'(1);
      ph_n = (ph_q == stride - STW'(1)) ? '0 : ph_q + STW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      fi_q <= '0;
    end else begin
      ph_q <= ph_n;
      fi_q <= fi_n;
    end
  end

  assign covered = (ph_q == '0);
  assign fidx    = fi_q;

  AST_FLAG_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && covered) |-> (fi_q < FW'(NFLAGS))); // R4

endmodule

// File: rtl/dbi_enc.sv
module dbi_enc
  import dbi_codec_pkg::*;
#(
  parameter int SLOT_BYTES     = 64,
  parameter int MAX_FLAG_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [7:0]                    hdr,
  input  logic [$clog2(SLOT_BYTES+1)-1:0] size,
  input  logic [(SLOT_BYTES-1)*8-1:0]   payload,
  output logic                          busy,
  output logic                          out_valid,
  output logic                          out_first,
  output logic                          out_last,
  output logic [7:0]                    out_byte
);

  localparam int PAY_BYTES = SLOT_BYTES - 1;
  localparam int PW        = PAY_BYTES * 8;
  localparam int NFL       = 8 * MAX_FLAG_BYTES;
  localparam int FW        = $clog2(NFL + 1);
  localparam int PSW       = $clog2(SLOT_BYTES + MAX_FLAG_BYTES + 1);

  enc_state_e     st_q, st_n;
  logic [7:0]     hdr_q, hdr_n, prev_q, prev_n;
  logic [1:0]     mode_q, mode_n, mode_in;
  logic [PSW-1:0] n_q, n_n, n_in, cnt_q, cnt_n, stride_q, stride_n;
  logic [PW-1:0]  pay_q, pay_n;
  logic [NFL-1:0] flags_q, flags_n;

  logic [PSW-1:0] mode_ext, total, pidx, psel;
  logic [7:0]     cur, enc_b, flag_b, hdr_tx;
  logic           w_cov, w_clr, w_adv, cov, inv_scan, inv_send, in_pay, last_scan;
  logic [FW-1:0]  w_fidx;

  assign mode_ext  = PSW'(mode_q);
  assign total     = PSW'(1) + mode_ext + n_q;
  assign in_pay    = (st_q == ST_SEND) && (cnt_q > mode_ext);
  assign last_scan = (st_q == ST_SCAN) && (cnt_q == n_q - PSW'(1));
  assign pidx      = (st_q == ST_SCAN) ? cnt_q : cnt_q - PSW'(1) - mode_ext;
  assign psel      = (pidx < PSW'(PAY_BYTES)) ? pidx : '0;
  assign cur       = pay_q[32'(psel)*8 +: 8];
  assign cov       = w_cov && (mode_q != 2'd0);
  assign inv_scan  = cov && (ones8(cur ^ prev_q) > 4'd4);
  assign enc_b     = cur ^ {8{inv_scan}};
  assign inv_send  = cov && flags_q[w_fidx];
  assign hdr_tx    = {hdr_q[7:MODE_LSB+2], mode_q, hdr_q[MODE_LSB-1:0]};

  assign n_in    = (size == '0) ? '0 : PSW'(size) - PSW'(1);
  assign mode_in = pick_mode(32'(size), SLOT_BYTES, MAX_FLAG_BYTES);

  assign w_clr = ((st_q == ST_IDLE) && start) || last_scan;
  assign w_adv = (mode_q != 2'd0) && ((st_q == ST_SCAN) || in_pay);

  dbi_walk #(.STW(PSW), .FW(FW), .NFLAGS(NFL)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(w_clr), .adv(w_adv),
    .stride(stride_q), .covered(w_cov), .fidx(w_fidx)
  );

  always_comb begin
    flag_b = '0;
    for (int j = 0; j < MAX_FLAG_BYTES; j++)
      if (cnt_q == PSW'(j + 1)) flag_b = flags_q[j*8 +: 8];
  end

  always_comb begin
    st_n = st_q; hdr_n = hdr_q; prev_n = prev_q; mode_n = mode_q;
    n_n = n_q; cnt_n = cnt_q; stride_n = stride_q; pay_n = pay_q;
    flags_n = flags_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        hdr_n    = hdr;
        mode_n   = mode_in;
        n_n      = n_in;
        pay_n    = payload;
        stride_n = PSW'(pick_stride(32'(n_in), 32'(mode_in), SLOT_BYTES));
        flags_n  = '0;
        cnt_n    = '0;
        prev_n   = {hdr[7:MODE_LSB+2], mode_in, hdr[MODE_LSB-1:0]};
        st_n     = (n_in == '0) ? ST_SEND : ST_SCAN;
      end
      ST_SCAN: begin
        prev_n = enc_b;
        if (inv_scan) flags_n[w_fidx] = 1'b1;
        cnt_n = cnt_q + PSW'(1);
        if (last_scan) begin
          cnt_n = '0;
          st_n  = ST_SEND;
        end
      end
      ST_SEND: begin
        cnt_n = cnt_q + PSW'(1);
        if (cnt_q == total - PSW'(1)) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; hdr_q <= '0; prev_q <= '0; mode_q <= '0;
      n_q <= '0; cnt_q <= '0; stride_q <= '0; pay_q <= '0; flags_q <= '0;
    end else begin
      st_q <= st_n; hdr_q <= hdr_n; prev_q <= prev_n; mode_q <= mode_n;
      n_q <= n_n; cnt_q <= cnt_n; stride_q <= stride_n; pay_q <= pay_n;
      flags_q <= flags_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign out_valid = (st_q == ST_SEND);
  assign out_first = out_valid && (cnt_q == '0);
  assign out_last  = out_valid && (cnt_q == total - PSW'(1));
  assign out_byte  = (cnt_q == '0) ? hdr_tx :
                     (cnt_q <= mode_ext) ? flag_b : (cur ^ {8{inv_send}});

  AST_MODE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |->
      (PSW'(out_byte[MODE_LSB+1:MODE_LSB]) + n_q + PSW'(1) <= PSW'(SLOT_BYTES))); // R1
  AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid); // R2
  AST_FRAME_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid); // R2
  AST_TOGGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SCAN) && cov) |-> (ones8(enc_b ^ prev_q) <= 4'd4)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_q)); // R9

endmodule

// File: rtl/dbi_dec.sv
module dbi_dec
  import dbi_codec_pkg::*;
#(
  parameter int SLOT_BYTES     = 64,
  parameter int MAX_FLAG_BYTES = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic                            in_first,
  input  logic [7:0]                      in_byte,
  input  logic [$clog2(SLOT_BYTES+1)-1:0] size,
  output logic                            out_valid,
  output logic                            out_first,
  output logic                            out_last,
  output logic [7:0]                      out_byte
);

  localparam int NFL = 8 * MAX_FLAG_BYTES;
  localparam int FW  = $clog2(NFL + 1);
  localparam int PSW = $clog2(SLOT_BYTES + MAX_FLAG_BYTES + 1);

  logic           act_q, act_n, ov_q, ov_n, of_q, of_n, ol_q, ol_n;
  logic [7:0]     ob_q, ob_n;
  logic [1:0]     mode_q, mode_n, mode_in;
  logic [PSW-1:0] n_q, n_n, n_in, cnt_q, cnt_n, stride_q, stride_n, mode_ext, total;
  logic [NFL-1:0] flags_q, flags_n;
  logic           w_cov, w_clr, w_adv, take, in_pay, inv;
  logic [FW-1:0]  w_fidx;

  assign mode_in  = in_byte[MODE_LSB+1:MODE_LSB];
  assign n_in     = (size == '0) ? '0 : PSW'(size) - PSW'(1);
  assign mode_ext = PSW'(mode_q);
  assign total    = PSW'(1) + mode_ext + n_q;
  assign take     = in_valid && !in_first && act_q;
  assign in_pay   = take && (cnt_q > mode_ext);
  assign inv      = w_cov && (mode_q != 2'd0) && flags_q[w_fidx];
  assign w_clr    = in_valid && in_first;
  assign w_adv    = in_pay && (mode_q != 2'd0);

  dbi_walk #(.STW(PSW), .FW(FW), .NFLAGS(NFL)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(w_clr), .adv(w_adv),
    .stride(stride_q), .covered(w_cov), .fidx(w_fidx)
  );

  always_comb begin
    act_n = act_q; mode_n = mode_q; n_n = n_q; cnt_n = cnt_q;
    stride_n = stride_q; flags_n = flags_q;
    ov_n = 1'b0; of_n = 1'b0; ol_n = 1'b0; ob_n = ob_q;
    if (in_valid && in_first) begin
      mode_n   = mode_in;
      n_n      = n_in;
      stride_n = PSW'(pick_stride(32'(n_in), 32'(mode_in), SLOT_BYTES));
      flags_n  = '0;
      cnt_n    = PSW'(1);
      act_n    = (n_in != '0) || (mode_in != 2'd0);
      ov_n     = 1'b1;
      of_n     = 1'b1;
      ol_n     = (n_in == '0);
      ob_n     = in_byte;
    end else if (take) begin
      cnt_n = cnt_q + PSW'(1);
      if (cnt_q == total - PSW'(1)) act_n = 1'b0;
      if (in_pay) begin
        ov_n = 1'b1;
        ol_n = (cnt_q == total - PSW'(1));
        ob_n = in_byte ^ {8{inv}};
      end else begin
        for (int j = 0; j < MAX_FLAG_BYTES; j++)
          if (cnt_q == PSW'(j + 1)) flags_n[j*8 +: 8] = in_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; mode_q <= '0; n_q <= '0; cnt_q <= '0; stride_q <= '0;
      flags_q <= '0; ov_q <= 1'b0; of_q <= 1'b0; ol_q <= 1'b0; ob_q <= '0;
    end else begin
      act_q <= act_n; mode_q <= mode_n; n_q <= n_n; cnt_q <= cnt_n;
      stride_q <= stride_n; flags_q <= flags_n;
      ov_q <= ov_n; of_q <= of_n; ol_q <= ol_n; ob_q <= ob_n;
    end
  end

  assign out_valid = ov_q;
  assign out_first = of_q;
  assign out_last  = ol_q;
  assign out_byte  = ob_q;

  AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> $past(in_valid)); // R7
  AST_FLAG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_pay) |=> !ov_q); // R7

endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int SLOT_BYTES     = 64,
  parameter int MAX_FLAG_BYTES = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tx_start,
  input  logic [7:0]                      tx_hdr,
  input  logic [$clog2(SLOT_BYTES+1)-1:0] tx_size,
  input  logic [(SLOT_BYTES-1)*8-1:0]     tx_payload,
  output logic                            tx_busy,
  output logic                            tx_valid,
  output logic                            tx_first,
  output logic                            tx_last,
  output logic [7:0]                      tx_byte,
  input  logic                            rx_valid,
  input  logic                            rx_first,
  input  logic [$clog2(SLOT_BYTES+1)-1:0] rx_size,
  input  logic [7:0]                      rx_byte,
  output logic                            rx_out_valid,
  output logic                            rx_out_first,
  output logic                            rx_out_last,
  output logic [7:0]                      rx_out_byte
);

  dbi_enc #(.SLOT_BYTES(SLOT_BYTES), .MAX_FLAG_BYTES(MAX_FLAG_BYTES)) u_enc (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .hdr(tx_hdr), .size(tx_size),
    .payload(tx_payload), .busy(tx_busy), .out_valid(tx_valid),
    .out_first(tx_first), .out_last(tx_last), .out_byte(tx_byte)
  );

  dbi_dec #(.SLOT_BYTES(SLOT_BYTES), .MAX_FLAG_BYTES(MAX_FLAG_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_first(rx_first),
    .in_byte(rx_byte), .size(rx_size), .out_valid(rx_out_valid),
    .out_first(rx_out_first), .out_last(rx_out_last), .out_byte(rx_out_byte)
  );

endmodule

// File: tb/dbi_codec_bench.sv
module dbi_codec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [6:0] V_SIZE [NV] = '{7'd1, 7'd2, 7'd10, 7'd17, 7'd30,
                                         7'd40, 7'd61, 7'd62, 7'd63, 7'd64};
  localparam logic [1:0] V_MODE [NV] = '{2'd0, 2'd3, 2'd3, 2'd3, 2'd3,
                                         2'd3, 2'd3, 2'd2, 2'd1, 2'd0};

  logic clk, rst_n, tx_start, tx_busy, tx_valid, tx_first, tx_last;
  logic [7:0] tx_hdr, tx_byte, rx_out_byte;
  logic [6:0] tx_size, cur_size;
  logic [503:0] tx_payload;
  logic rx_out_valid, rx_out_first, rx_out_last;

  int tests, fails;
  logic [7:0] pb [64];
  logic [7:0] exp_s [128];
  logic [7:0] dexp [128];
  logic [7:0] txs [128];
  logic [7:0] rxs [128];
  int exp_n, dexp_n, tx_n, rx_n, lat;
  logic first_ok, last_ok;

  dbi_codec u_dbi_codec (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_hdr(tx_hdr),
    .tx_size(tx_size), .tx_payload(tx_payload), .tx_busy(tx_busy),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
    .tx_byte(tx_byte), .rx_valid(tx_valid), .rx_first(tx_first),
    .rx_size(cur_size), .rx_byte(tx_byte), .rx_out_valid(rx_out_valid),
    .rx_out_first(rx_out_first), .rx_out_last(rx_out_last),
    .rx_out_byte(rx_out_byte)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rx_out_valid && rx_n < 128) begin
      rxs[rx_n] = rx_out_byte;
      rx_n = rx_n + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] bits8(input logic [7:0] b);
    logic [3:0] c;
    c = 0;
    for (int i = 0; i < 8; i++) if (b[i]) c++;
    return c;
  endfunction

  task automatic fill_seed(input int seed);
    for (int i = 0; i < 64; i++) pb[i] = 8'((seed * 29 + i * 53 + i * i * seed) ^ (i * 7));
  endtask

  // independent frame model built from R1..R7
  task automatic model(input int size, input logic [7:0] hdr, input int k);
    int n, s, fi;
    logic [7:0] prev, e, htx;
    logic [23:0] fl;
    n = (size > 0) ? size - 1 : 0;
    s = (k > 0) ? (n + 8 * k - 1) / (8 * k) : 1;
    htx = {hdr[7:5], 2'(k), hdr[2:0]};
    fl = 0; fi = 0; prev = htx;
    for (int i = 0; i < n; i++) begin
      e = pb[i];
      if (k > 0 && (i % s) == 0) begin
        if (bits8(pb[i] ^ prev) > 4) begin e = ~pb[i]; fl[fi] = 1'b1; end
        fi++;
      end
      exp_s[1 + k + i] = e;
      prev = e;
    end
    exp_s[0] = htx;
    for (int j = 0; j < k; j++) exp_s[1 + j] = fl[j*8 +: 8];
    exp_n = 1 + k + n;
    dexp[0] = htx;
    for (int i = 0; i < n; i++) dexp[1 + i] = pb[i];
    dexp_n = 1 + n;
  endtask

  task automatic run(input int size, input logic [7:0] hdr, input logic garble);
    int c, t;
    rx_n = 0;
    tx_size = 7'(size); cur_size = 7'(size); tx_hdr = hdr;
    for (int i = 0; i < 63; i++) tx_payload[i*8 +: 8] = pb[i];
    tx_start = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_start = 1'b0;
    c = 0;
    while (!tx_valid && c < 300) begin
      if (garble && c == 1) begin
        tx_start = 1'b1; tx_size = 7'd5; tx_hdr = 8'hFF; tx_payload = '1;
      end
      if (garble && c == 3) tx_start = 1'b0;
      @(negedge clk); c++;
    end
    lat = c;
    t = 0; first_ok = tx_first; last_ok = 1'b1;
    while (tx_valid && t < 128) begin
      txs[t] = tx_byte;
      if (tx_last != (t == exp_n - 1)) last_ok = 1'b0;
      if (t > 0 && tx_first) first_ok = 1'b0;
      t++;
      @(negedge clk);
    end
    tx_n = t;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input int size, input int k);
    int bad_tx, bad_rx;
    logic [7:0] a, e;
    chk(txs[0][4:3] == 2'(k), "R1 budget field", 32'(txs[0][4:3]), 32'(k));
    chk(txs[0] == exp_s[0], "R1 header bits", 32'(txs[0]), 32'(exp_s[0]));
    chk(lat == size - 1 || (size <= 1 && lat == 0), "R2 latency", 32'(lat), 32'(size > 0 ? size - 1 : 0));
    chk(tx_n == exp_n && first_ok && last_ok, "R2 framing", 32'(tx_n), 32'(exp_n));
    bad_tx = 0; a = 0; e = 0;
    for (int i = 0; i < exp_n; i++)
      if (txs[i] !== exp_s[i] && bad_tx++ == 0) begin a = txs[i]; e = exp_s[i]; end
    chk(bad_tx == 0, {tag, " R3/R4/R5/R6 stream"}, 32'(a), 32'(e));
    bad_rx = 0; a = 0; e = 0;
    for (int i = 0; i < dexp_n; i++)
      if (rxs[i] !== dexp[i] && bad_rx++ == 0) begin a = rxs[i]; e = dexp[i]; end
    chk(bad_rx == 0 && rx_n == dexp_n, {tag, " R7 restore"}, 32'(a), 32'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; rx_n = 0;
    rst_n = 1'b0; tx_start = 1'b0; tx_hdr = '0; tx_size = '0; cur_size = '0;
    tx_payload = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!tx_busy && !tx_valid && !rx_out_valid, "R8 reset outputs",
        {29'd0, tx_busy, tx_valid, rx_out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of sizes with expected budget
    for (int v = 0; v < NV; v++) begin
      fill_seed(v + 3);
      model(int'(V_SIZE[v]), 8'(8'hA5 ^ 8'(v * 17)), int'(V_MODE[v]));
      run(int'(V_SIZE[v]), 8'(8'hA5 ^ 8'(v * 17)), 1'b0);
      check_frame($sformatf("vec%0d", v), int'(V_SIZE[v]), int'(V_MODE[v]));
    end

    // R3 and R6: exactly 4 toggles against sent header stays true, 5 inverts
    for (int i = 0; i < 64; i++) pb[i] = 8'h00;
    pb[0] = 8'h17; pb[1] = 8'h08;
    run(3, 8'h00, 1'b0);
    chk(tx_n == 6, "R3 threshold length", 32'(tx_n), 32'd6);
    chk({txs[0], txs[1], txs[2], txs[3]} == 32'h18020000, "R5 threshold flags",
        {txs[0], txs[1], txs[2], txs[3]}, 32'h18020000);
    chk(txs[4] == 8'h17, "R3 four toggles sent true (R6 header ref)", 32'(txs[4]), 32'h17);
    chk(txs[5] == 8'hF7, "R3 five toggles inverted", 32'(txs[5]), 32'hF7);

    // R4: stride 2, uncovered bytes sent true
    for (int i = 0; i < 64; i++) pb[i] = (i % 2 == 1) ? 8'hFF : 8'h00;
    run(30, 8'h00, 1'b0);
    chk({txs[0], txs[1], txs[2], txs[3]} == 32'h18FE7F00, "R5 stride flags",
        {txs[0], txs[1], txs[2], txs[3]}, 32'h18FE7F00);
    chk(txs[4] == 8'h00 && txs[5] == 8'hFF, "R4 first pair", {16'd0, txs[4], txs[5]}, 32'h00FF);
    begin
      int bad;
      bad = 0;
      for (int i = 5; i < 33; i++) if (txs[i] != 8'hFF) bad++;
      chk(bad == 0 && tx_n == 33, "R4 uncovered bytes true", 32'(bad), 32'd0);
    end

    // R9: start raised mid-scan with other inputs
    fill_seed(77);
    model(40, 8'h3C, 3);
    run(40, 8'h3C, 1'b1);
    check_frame("R9 busy start", 40, 3);
    @(negedge clk);
    chk(!tx_busy && !tx_valid, "R9 no extra frame", {30'd0, tx_busy, tx_valid}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule